// File: doc/BRIEF.md
# Two-Master Spoke Arbiter

This block sits at the centre of an on-chip hub and decides, cycle by cycle, which of two bus masters may drive each of eight independent peripheral buses (spokes). One master is the processor port, the other is the direct-memory-access engine. Each spoke is owned by at most one master at a time. When the two masters aim at different spokes, both are granted together.

The DMA side carries 24 channel requests. Each channel has a 3-bit priority level and a 3-bit target spoke. Level 0 is the most urgent. Among pending channels the most urgent one is chosen, and on equal levels the lowest channel number is chosen. A DMA grant covers one burst. It is held until the engine signals the end of that burst. The spoke is then released, and the engine must win arbitration again for its next burst. The processor wins a simultaneous contest for the same spoke. It never pre-empts a burst already granted to the DMA. A lock flag lets the processor keep its spoke across cycles.

The processor side is a state machine with states C_IDLE and C_OWN:
- C_IDLE→C_OWN is taken on a request that is not blocked.
- C_OWN→C_OWN is taken on lock hold, or on a new unblocked request.
- C_OWN→C_IDLE is taken when there is no request and no lock, or when the request is blocked.

The DMA side has states D_IDLE and D_BURST:
- D_IDLE→D_BURST is taken when a winner exists and its spoke is free of the processor's next grant.
- D_BURST→D_BURST is taken while the burst continues.
- D_BURST→D_IDLE is taken on burst end.

All grants are registered, so they change on the clock edge that samples the inputs.

Top module: `hub_arbiter`

## Requirements
- R1: After reset, cpu_gnt and dma_gnt are 0, cpu_sel and dma_sel are all zero, and dma_win_ch is 0.
- R2: If cpu_req is sampled with spoke s, and no DMA burst is continuing on spoke s, then in the next cycle cpu_gnt is 1 and cpu_sel has only bit s set. Without a request and without an effective lock, cpu_gnt is 0 in the next cycle and cpu_sel is zero.
- R3: A processor request to one spoke and a DMA winner on a different spoke, both sampled while neither master holds a grant, are granted together in the next cycle.
- R4: If both masters target the same spoke in the same cycle while neither holds a grant, the processor is granted and the DMA is not.
- R5: The DMA winner is the pending channel with the smallest priority value, and ties go to the lowest channel number. Channel c's priority is dma_ch_prio[3c+2:3c] and its spoke is dma_ch_spoke[3c+2:3c]. dma_win_ch reports the winner and dma_sel has only bit (winner's spoke) set.
- R6: While dma_gnt is 1 and dma_burst_end is 0, the next cycle keeps dma_gnt, dma_win_ch and dma_sel unchanged. A processor request to that spoke is not granted in this case.
- R7: If dma_burst_end is sampled while dma_gnt is 1, dma_gnt is 0 in the next cycle. A processor request waiting for that spoke is granted in that same next cycle.
- R8: If cpu_gnt is 1 and cpu_lock is sampled as 1, the next cycle keeps cpu_gnt at 1 on the same spoke, whatever cpu_req and cpu_spoke are.
- R9: cpu_sel and dma_sel never have a common bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Processor requests a spoke |
| cpu_spoke | input | 3 | Processor target spoke index |
| cpu_lock | input | 1 | Processor keeps its current spoke |
| dma_ch_req | input | 24 | Pending DMA channel requests |
| dma_ch_prio | input | 72 | Priority level per channel, 3 bits each, 0 most urgent |
| dma_ch_spoke | input | 72 | Target spoke per channel, 3 bits each |
| dma_burst_end | input | 1 | DMA engine finishes its current burst |
| cpu_gnt | output | 1 | Processor holds a spoke |
| cpu_sel | output | 8 | One-hot spoke held by the processor |
| dma_gnt | output | 1 | DMA holds a spoke for a burst |
| dma_sel | output | 8 | One-hot spoke held by the DMA |
| dma_win_ch | output | 5 | Channel whose burst is granted |

## Verification
The bench builds the block with its default parameters: eight spokes, 24 channels and 3-bit priority levels.

This configuration reaches the corner cases that matter:
- ties among channels that share a level and sit at both ends of the 24-entry channel range;
- processor and DMA contests on every spoke;
- bursts that are held for many cycles while the processor waits;
- lock holds that overlap a release.

Directed sequences pin down the tie rule, the hold and release timing, and the lock behaviour. Seeded random traffic then mixes all of them against a cycle model of the requirements.

// File: rtl/hub_arb_pkg.sv
package hub_arb_pkg;
    typedef enum logic {
        C_IDLE = 1'b0,
        C_OWN  = 1'b1
    } cpu_state_e;

    typedef enum logic {
        D_IDLE  = 1'b0,
        D_BURST = 1'b1
    } dma_state_e;
endpackage

// File: rtl/hub_dma_select.sv
module hub_dma_select #(
    parameter int NUM_CH  = 24,
    parameter int PRIO_W  = 3,
    parameter int SPOKE_W = 3,
    localparam int CH_W   = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0]          ch_req,
    input  logic [NUM_CH*PRIO_W-1:0]   ch_prio,
    input  logic [NUM_CH*SPOKE_W-1:0]  ch_spoke,
    output logic                       found,
    output logic [CH_W-1:0]            win_ch,
    output logic [SPOKE_W-1:0]         win_spoke
);
    logic [PRIO_W-1:0] best_prio;

    // Linear scan: a strictly smaller level replaces the incumbent, so on
    // equal levels the lowest channel number is kept.
    always_comb begin
        found     = 1'b0;
        win_ch    = '0;
        win_spoke = '0;
        best_prio = '1;
        for (int i = 0; i < NUM_CH; i++) begin
            if (ch_req[i] && (!found || ch_prio[i*PRIO_W +: PRIO_W] < best_prio)) begin
                found     = 1'b1;
                win_ch    = CH_W'(i);
                best_prio = ch_prio[i*PRIO_W +: PRIO_W];
                win_spoke = ch_spoke[i*SPOKE_W +: SPOKE_W];
            end
        end
    end
endmodule

// File: rtl/hub_cpu_fsm.sv
module hub_cpu_fsm
    import hub_arb_pkg::*;
#(
    parameter int SPOKE_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_req,
    input  logic [SPOKE_W-1:0] cpu_spoke,
    input  logic               cpu_lock,
    input  logic               dma_keep,
    input  logic [SPOKE_W-1:0] dma_keep_spoke,
    output logic               nxt_gnt,
    output logic [SPOKE_W-1:0] nxt_spoke,
    output logic               gnt,
    output logic [SPOKE_W-1:0] spoke_q
);
    cpu_state_e state, state_n;
    logic       blocked;

    assign blocked = dma_keep && (dma_keep_spoke == cpu_spoke);

    always_comb begin
        state_n   = C_IDLE;
        nxt_spoke = '0;
        unique case (state)
            C_IDLE: begin
                if (cpu_req && !blocked) begin
                    state_n   = C_OWN;
                    nxt_spoke = cpu_spoke;
                end
            end
            C_OWN: begin
                if (cpu_lock) begin
                    state_n   = C_OWN;
                    nxt_spoke = spoke_q;
                end else if (cpu_req && !blocked) begin
                    state_n   = C_OWN;
                    nxt_spoke = cpu_spoke;
                end
            end
            default: state_n = C_IDLE;
        endcase
        nxt_gnt = (state_n == C_OWN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= C_IDLE;
            spoke_q <= '0;
        end else begin
            state   <= state_n;
            spoke_q <= nxt_spoke;
        end
    end

    always_comb begin
        gnt = (state == C_OWN);
    end

    assert_lock_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt && cpu_lock) |=> (gnt && $stable(spoke_q)));

    assert_no_grant_into_burst_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!(gnt && cpu_lock) && blocked) |=> !(gnt && spoke_q == $past(cpu_spoke)));
endmodule

// File: rtl/hub_dma_fsm.sv
module hub_dma_fsm
    import hub_arb_pkg::*;
#(
    parameter int CH_W    = 5,
    parameter int SPOKE_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               found,
    input  logic [CH_W-1:0]    win_ch,
    input  logic [SPOKE_W-1:0] win_spoke,
    input  logic               burst_end,
    input  logic               cpu_nxt_gnt,
    input  logic [SPOKE_W-1:0] cpu_nxt_spoke,
    output logic               keep,
    output logic               gnt,
    output logic [CH_W-1:0]    ch_q,
    output logic [SPOKE_W-1:0] spoke_q
);
    dma_state_e         state, state_n;
    logic [CH_W-1:0]    ch_n;
    logic [SPOKE_W-1:0] spoke_n;

    always_comb begin
        state_n = state;
        ch_n    = ch_q;
        spoke_n = spoke_q;
        unique case (state)
            D_IDLE: begin
                ch_n    = '0;
                spoke_n = '0;
                if (found && !(cpu_nxt_gnt && cpu_nxt_spoke == win_spoke)) begin
                    state_n = D_BURST;
                    ch_n    = win_ch;
                    spoke_n = win_spoke;
                end
            end
            D_BURST: begin
                if (burst_end) begin
                    state_n = D_IDLE;
                    ch_n    = '0;
                    spoke_n = '0;
                end
            end
            default: state_n = D_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= D_IDLE;
            ch_q    <= '0;
            spoke_q <= '0;
        end else begin
            state   <= state_n;
            ch_q    <= ch_n;
            spoke_q <= spoke_n;
        end
    end

    always_comb begin
        gnt  = (state == D_BURST);
        keep = (state == D_BURST) && !burst_end;
    end

    assert_burst_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt && !burst_end) |=> (gnt && $stable(ch_q) && $stable(spoke_q)));

    assert_burst_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt && burst_end) |=> !gnt);
endmodule

// File: rtl/hub_arbiter.sv
module hub_arbiter #(
    parameter int NUM_SPOKES = 8,
    parameter int NUM_CH     = 24,
    parameter int PRIO_W     = 3,
    localparam int SPOKE_W   = $clog2(NUM_SPOKES),
    localparam int CH_W      = $clog2(NUM_CH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cpu_req,
    input  logic [SPOKE_W-1:0]        cpu_spoke,
    input  logic                      cpu_lock,
    input  logic [NUM_CH-1:0]         dma_ch_req,
    input  logic [NUM_CH*PRIO_W-1:0]  dma_ch_prio,
    input  logic [NUM_CH*SPOKE_W-1:0] dma_ch_spoke,
    input  logic                      dma_burst_end,
    output logic                      cpu_gnt,
    output logic [NUM_SPOKES-1:0]     cpu_sel,
    output logic                      dma_gnt,
    output logic [NUM_SPOKES-1:0]     dma_sel,
    output logic [CH_W-1:0]           dma_win_ch
);
    logic               sel_found;
    logic [CH_W-1:0]    sel_ch;
    logic [SPOKE_W-1:0] sel_spoke;
    logic               cpu_nxt_gnt;
    logic [SPOKE_W-1:0] cpu_nxt_spoke;
    logic [SPOKE_W-1:0] cpu_spoke_q;
    logic               dma_keep;
    logic [SPOKE_W-1:0] dma_spoke_q;

    hub_dma_select #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W), .SPOKE_W(SPOKE_W)) u_select (
        .ch_req    (dma_ch_req),
        .ch_prio   (dma_ch_prio),
        .ch_spoke  (dma_ch_spoke),
        .found     (sel_found),
        .win_ch    (sel_ch),
        .win_spoke (sel_spoke)
    );

    hub_cpu_fsm #(.SPOKE_W(SPOKE_W)) u_cpu (
        .clk            (clk),
        .rst_n          (rst_n),
        .cpu_req        (cpu_req),
        .cpu_spoke      (cpu_spoke),
        .cpu_lock       (cpu_lock),
        .dma_keep       (dma_keep),
        .dma_keep_spoke (dma_spoke_q),
        .nxt_gnt        (cpu_nxt_gnt),
        .nxt_spoke      (cpu_nxt_spoke),
        .gnt            (cpu_gnt),
        .spoke_q        (cpu_spoke_q)
    );

    hub_dma_fsm #(.CH_W(CH_W), .SPOKE_W(SPOKE_W)) u_dma (
        .clk           (clk),
        .rst_n         (rst_n),
        .found         (sel_found),
        .win_ch        (sel_ch),
        .win_spoke     (sel_spoke),
        .burst_end     (dma_burst_end),
        .cpu_nxt_gnt   (cpu_nxt_gnt),
        .cpu_nxt_spoke (cpu_nxt_spoke),
        .keep          (dma_keep),
        .gnt           (dma_gnt),
        .ch_q          (dma_win_ch),
        .spoke_q       (dma_spoke_q)
    );

    for (genvar s = 0; s < NUM_SPOKES; s++) begin : g_sel
        assign cpu_sel[s] = cpu_gnt && (cpu_spoke_q == SPOKE_W'(s));
        assign dma_sel[s] = dma_gnt && (dma_spoke_q == SPOKE_W'(s));
    end

    assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_sel & dma_sel) == '0);

    assert_cpu_wins_tie_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_gnt && !dma_gnt && cpu_req && sel_found && sel_spoke == cpu_spoke)
        |=> (cpu_gnt && !dma_gnt));

    assert_dual_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_gnt && !dma_gnt && cpu_req && sel_found && sel_spoke != cpu_spoke)
        |=> (cpu_gnt && dma_gnt));

    assert_sel_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cpu_sel) && $onehot0(dma_sel));
endmodule

// File: tb/hub_arbiter_tb.sv
`timescale 1ns/1ps
module hub_arbiter_tb;
    localparam int NS = 8;
    localparam int NC = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic [2:0]  cpu_spoke = '0;
    logic        cpu_lock = 1'b0;
    logic [23:0] dma_ch_req = '0;
    logic [71:0] dma_ch_prio = '0;
    logic [71:0] dma_ch_spoke = '0;
    logic        dma_burst_end = 1'b0;
    logic        cpu_gnt, dma_gnt;
    logic [7:0]  cpu_sel, dma_sel;
    logic [4:0]  dma_win_ch;

    int errors = 0;
    int checks = 0;

    // cycle model of the requirements
    logic       m_cg = 0, m_dg = 0;
    logic [2:0] m_cs = 0, m_ds = 0;
    logic [4:0] m_dc = 0;

    always #2 clk = ~clk;

    hub_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_spoke(cpu_spoke),
        .cpu_lock(cpu_lock), .dma_ch_req(dma_ch_req), .dma_ch_prio(dma_ch_prio),
        .dma_ch_spoke(dma_ch_spoke), .dma_burst_end(dma_burst_end),
        .cpu_gnt(cpu_gnt), .cpu_sel(cpu_sel), .dma_gnt(dma_gnt),
        .dma_sel(dma_sel), .dma_win_ch(dma_win_ch)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int pick(input logic [23:0] req, input logic [71:0] pr);
        int best = -1;
        for (int i = 0; i < NC; i++)
            if (req[i] && (best < 0 || pr[i*3 +: 3] < pr[best*3 +: 3])) best = i;
        return best;
    endfunction

    function automatic logic [7:0] onehot(input logic g, input logic [2:0] s);
        return g ? (8'b1 << s) : 8'b0;
    endfunction

    task automatic model_step();
        logic       ncg, ndg;
        logic [2:0] ncs, nds;
        logic [4:0] ndc;
        int w;
        if (m_cg && cpu_lock) begin
            ncg = 1; ncs = m_cs;
        end else if (cpu_req && !(m_dg && !dma_burst_end && m_ds == cpu_spoke)) begin
            ncg = 1; ncs = cpu_spoke;
        end else begin
            ncg = 0; ncs = 0;
        end
        if (m_dg) begin
            if (dma_burst_end) begin ndg = 0; ndc = 0; nds = 0; end
            else begin ndg = 1; ndc = m_dc; nds = m_ds; end
        end else begin
            w = pick(dma_ch_req, dma_ch_prio);
            ndg = 0; ndc = 0; nds = 0;
            if (w >= 0 && !(ncg && ncs == dma_ch_spoke[w*3 +: 3])) begin
                ndg = 1; ndc = 5'(w); nds = dma_ch_spoke[w*3 +: 3];
            end
        end
        m_cg = ncg; m_cs = ncs; m_dg = ndg; m_dc = ndc; m_ds = nds;
    endtask

    task automatic compare(input string tag);
        check(tag, "cpu_gnt", cpu_gnt, m_cg);
        check(tag, "cpu_sel", cpu_sel, onehot(m_cg, m_cs));
        check(tag, "dma_gnt", dma_gnt, m_dg);
        check(tag, "dma_sel", dma_sel, onehot(m_dg, m_ds));
        check(tag, "dma_win_ch", dma_win_ch, m_dc);
        check("R9", "overlap", int'(cpu_sel & dma_sel), 0);
    endtask

    task automatic tick(input string tag);
        model_step();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic set_ch(input int c, input logic r, input logic [2:0] p, input logic [2:0] s);
        dma_ch_req[c] = r;
        dma_ch_prio[c*3 +: 3] = p;
        dma_ch_spoke[c*3 +: 3] = s;
    endtask

    task automatic quiet();
        cpu_req = 0; cpu_lock = 0; dma_ch_req = '0; dma_burst_end = 1;
        tick("R7");
        dma_burst_end = 0;
        tick("R2");
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int unsigned seed = 32'h5a17c3e1;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "cpu_gnt", cpu_gnt, 0);
        check("R1", "dma_gnt", dma_gnt, 0);
        check("R1", "sel", int'({cpu_sel, dma_sel}), 0);
        check("R1", "dma_win_ch", dma_win_ch, 0);
        rst_n = 1;
        tick("R1");

        // R2 processor alone
        cpu_req = 1; cpu_spoke = 3;
        tick("R2");
        check("R2", "cpu_sel", cpu_sel, 8'h08);
        cpu_req = 0;
        tick("R2");
        check("R2", "cpu_gnt drop", cpu_gnt, 0);

        // R3 both masters on different spokes
        cpu_req = 1; cpu_spoke = 1; set_ch(5, 1, 2, 6);
        tick("R3");
        check("R3", "cpu_sel", cpu_sel, 8'h02);
        check("R3", "dma_sel", dma_sel, 8'h40);
        check("R3", "dma_win_ch", dma_win_ch, 5);
        quiet();

        // R4 same spoke contest
        cpu_req = 1; cpu_spoke = 4; set_ch(2, 1, 0, 4);
        tick("R4");
        check("R4", "cpu_gnt", cpu_gnt, 1);
        check("R4", "dma_gnt", dma_gnt, 0);
        quiet();

        // R5 priority and tie break
        set_ch(3, 1, 5, 0); set_ch(7, 1, 1, 2); set_ch(9, 1, 1, 5); set_ch(10, 1, 4, 1);
        tick("R5");
        check("R5", "dma_win_ch", dma_win_ch, 7);
        check("R5", "dma_sel", dma_sel, 8'h04);

        // R6 burst held while processor waits on the same spoke
        cpu_req = 1; cpu_spoke = 2;
        repeat (3) begin
            tick("R6");
            check("R6", "cpu_gnt", cpu_gnt, 0);
            check("R6", "dma_win_ch", dma_win_ch, 7);
        end
        // R7 release hands the spoke to the waiting processor
        dma_burst_end = 1;
        tick("R7");
        check("R7", "dma_gnt", dma_gnt, 0);
        check("R7", "cpu_sel", cpu_sel, 8'h04);
        dma_burst_end = 0; cpu_req = 0; set_ch(7, 0, 1, 2);
        tick("R5");
        check("R5", "tie winner", dma_win_ch, 9);
        quiet();

        // R5 ties at the top channel boundary
        set_ch(23, 1, 0, 7); set_ch(0, 1, 0, 3);
        tick("R5");
        check("R5", "low index tie", dma_win_ch, 0);
        quiet();

        // R8 lock holds the spoke despite input changes
        cpu_req = 1; cpu_spoke = 0;
        tick("R8");
        cpu_lock = 1; cpu_req = 0; cpu_spoke = 5;
        tick("R8");
        check("R8", "cpu_sel held", cpu_sel, 8'h01);
        set_ch(12, 1, 0, 0);
        tick("R8");
        check("R8", "dma kept off", dma_gnt, 0);
        quiet();

        // random mix
        for (int n = 0; n < 3000; n++) begin
            cpu_req = ($urandom % 2) == 0;
            cpu_spoke = 3'($urandom);
            cpu_lock = ($urandom % 4) == 0;
            dma_burst_end = ($urandom % 4) == 0;
            for (int c = 0; c < NC; c++)
                set_ch(c, ($urandom % 8) == 0, 3'($urandom), 3'($urandom));
            tick("R5");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule